// File: doc/BRIEF.md
# Write-Back Invalidate Snooping Cache Controller

This block keeps the coherence state of every line of a direct-mapped, write-back cache that shares one atomic bus with other caches. Each line holds a tag and one of three states: Invalid, Shared (readable copy) or Exclusive (the only copy, writable and dirty). The data array and main memory sit outside the block. The controller only decides, line by line, whether an access may complete locally and which bus transactions must be issued.

The processor side presents a block address with a read or write flag and holds it until the controller reports completion, flagged as a hit or a miss. On a miss the controller raises a bus request and waits for grant. If an Exclusive victim has to go, it first writes that block back and then places a read miss or a write miss. A write to a clean line is always treated as a miss, so exclusive ownership is always obtained on the bus. At the same time the controller watches the transactions of the other caches. When a read miss or a write miss from another cache matches a line it holds, it downgrades or invalidates that line. When the matching line is Exclusive, it also signals that it supplies the block and aborts the memory access.

All addresses are block addresses: the upper bits are the tag and the lower bits select the line. Because the bus carries one transaction at a time, the order of write misses on it is the single order of writes seen by every cache.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus request or transaction is driven, and no completion is reported; the first access to any block is a miss.
- R2: A read to a line in Shared or Exclusive state with a matching tag, and a write to an Exclusive line with a matching tag, complete in the cycle they are presented with cpu_hit=1, put nothing on the bus and leave the line unchanged.
- R3: A read that misses places a read miss (bus_cmd=1) carrying the requested block address and leaves the line Shared. Afterwards reads to that block hit and writes to it miss.
- R4: A write to an Invalid line, to a Shared line or to a line with another tag places a write miss (bus_cmd=2) carrying the requested block address and leaves the line Exclusive.
- R5: A miss that replaces an Exclusive line with another tag first issues a write-back (bus_cmd=3) carrying the victim's block address, then the read or write miss. The line ends Shared after a read and Exclusive after a write.
- R6: A snooped write miss that matches a Shared line makes it Invalid, so the next local read of that block misses.
- R7: A snooped read miss that matches an Exclusive line raises snp_flush in the same cycle as the snooped transaction (supply the block and abort memory) and leaves the line Shared.
- R8: A snooped write miss that matches an Exclusive line raises snp_flush in the same cycle and leaves the line Invalid.
- R9: A snooped transaction affects a line only when both index and tag match and the line is not Invalid. A miss to the same index with another tag leaves the local line and its state untouched. A snooped write-back never changes state.
- R10: A new processor request presented in a cycle that carries a snooped transaction is not completed in that cycle; it is served on a later cycle.
- R11: bus_valid is driven only in a cycle with both bus_req and bus_gnt. bus_req stays high until granted. A read miss or write miss completes the processor request in its grant cycle with cpu_hit=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request pending, held until cpu_done |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_blk | input | TAG_W+INDEX_W | Requested block address {tag, index} |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completion was a hit (no bus traffic) |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_valid | output | 1 | Own transaction on the bus this cycle |
| bus_cmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_blk | output | TAG_W+INDEX_W | Block address of the own transaction |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_blk | input | TAG_W+INDEX_W | Block address of the snooped transaction |
| snp_flush | output | 1 | This cache supplies the dirty block and aborts memory |

## Verification
The assertions watch, on every cycle, the port-level rules of the bus protocol. No transaction goes out without grant, a request is held until granted, and a write-back is followed by a pending miss. Hits never coincide with bus traffic, a miss completes in its grant cycle, a flush only answers a snooped miss, and a hit never completes while a snoop is present. Whether each line actually reaches the right state after a sequence of local and snooped events shows only in the bench. Two controllers share one bus there, and a reference model predicts hit or miss, write-backs with victim addresses, and peer flushes for directed ownership transfers and random conflicting traffic.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_RDMISS = 2'd1,
        CMD_WRMISS = 2'd2,
        CMD_WBACK  = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WBACK = 2'd1,
        PH_MISS  = 2'd2
    } phase_t;

endpackage

// File: rtl/line_store.sv
module line_store
    import snoop_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] cpu_idx,
    output line_st_t           cpu_st,
    output logic [TAG_W-1:0]   cpu_tag,
    input  logic [INDEX_W-1:0] snp_idx,
    output line_st_t           snp_st,
    output logic [TAG_W-1:0]   snp_tag,
    input  logic               upd_en,
    input  line_st_t           upd_st,
    input  logic               fill_en,
    input  logic [TAG_W-1:0]   fill_tag,
    input  line_st_t           fill_st
);
    localparam int LINES = 1 << INDEX_W;

    typedef struct packed {
        logic [LINES-1:0][1:0]       st;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } store_t;

    store_t store_d, store_q;

    // Two read ports: one for the processor lookup, one for the snoop lookup.
    assign cpu_st  = line_st_t'(store_q.st[cpu_idx]);
    assign cpu_tag = store_q.tag[cpu_idx];
    assign snp_st  = line_st_t'(store_q.st[snp_idx]);
    assign snp_tag = store_q.tag[snp_idx];

    always_comb begin
        store_d = store_q;
        // Atomic bus: a snoop update and an own fill never share a cycle.
        if (upd_en) begin
            store_d.st[snp_idx] = upd_st;
        end
        if (fill_en) begin
            store_d.st[cpu_idx]  = fill_st;
            store_d.tag[cpu_idx] = fill_tag;
        end
    end

    // R1: every line starts Invalid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

endmodule

// File: rtl/snoop_unit.sv
module snoop_unit
    import snoop_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snp_valid,
    input  bus_cmd_t         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_t         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             upd_en,
    output line_st_t         upd_st,
    output logic             flush
);
    logic match;

    // R9: tag and index (through the read port) must agree, line valid
    assign match = snp_valid && (line_st != LN_INV) && (line_tag == snp_tag);

    always_comb begin
        upd_en = 1'b0;
        upd_st = line_st;
        flush  = 1'b0;
        if (match) begin
            unique case (snp_cmd)
                CMD_RDMISS: begin
                    if (line_st == LN_EXC) begin  // R7
                        flush  = 1'b1;
                        upd_en = 1'b1;
                        upd_st = LN_SHR;
                    end
                end
                CMD_WRMISS: begin                 // R6, R8
                    flush  = (line_st == LN_EXC);
                    upd_en = 1'b1;
                    upd_st = LN_INV;
                end
                default: begin
                    upd_en = 1'b0;                // write-back: no change
                end
            endcase
        end
    end

endmodule

// File: rtl/proc_fsm.sv
module proc_fsm
    import snoop_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req_valid,
    input  logic                     cpu_req_write,
    input  logic [INDEX_W-1:0]       req_idx,
    input  logic [TAG_W-1:0]         req_tag,
    input  line_st_t                 line_st,
    input  logic [TAG_W-1:0]         line_tag,
    input  logic                     snp_valid,
    input  logic                     bus_gnt,
    output logic                     bus_req,
    output logic                     bus_valid,
    output bus_cmd_t                 bus_cmd,
    output logic [TAG_W+INDEX_W-1:0] bus_blk,
    output logic                     cpu_done,
    output logic                     cpu_hit,
    output logic                     fill_en,
    output line_st_t                 fill_st
);
    typedef struct packed {
        phase_t           ph;
        logic [TAG_W-1:0] vtag;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic tag_eq;
    logic hit;
    logic dirty_victim;

    always_comb begin
        tag_eq       = (line_tag == req_tag);
        hit          = tag_eq && (cpu_req_write ? (line_st == LN_EXC)
                                                : (line_st != LN_INV));
        dirty_victim = (line_st == LN_EXC) && !tag_eq;

        fsm_d     = fsm_q;
        bus_req   = 1'b0;
        bus_valid = 1'b0;
        bus_cmd   = CMD_NONE;
        bus_blk   = '0;
        cpu_done  = 1'b0;
        cpu_hit   = 1'b0;
        fill_en   = 1'b0;
        fill_st   = cpu_req_write ? LN_EXC : LN_SHR;

        unique case (fsm_q.ph)
            PH_IDLE: begin
                // R10: a snoop in this cycle defers acceptance
                if (cpu_req_valid && !snp_valid) begin
                    if (hit) begin                // R2
                        cpu_done = 1'b1;
                        cpu_hit  = 1'b1;
                    end else if (dirty_victim) begin
                        fsm_d.ph   = PH_WBACK;
                        fsm_d.vtag = line_tag;
                    end else begin
                        fsm_d.ph = PH_MISS;
                    end
                end
            end
            PH_WBACK: begin
                // A snoop may have taken the victim away while waiting.
                if ((line_st != LN_EXC) || (line_tag != fsm_q.vtag)) begin
                    fsm_d.ph = PH_MISS;
                end else begin
                    bus_req = 1'b1;
                    if (bus_gnt) begin            // R5
                        bus_valid = 1'b1;
                        bus_cmd   = CMD_WBACK;
                        bus_blk   = {fsm_q.vtag, req_idx};
                        fsm_d.ph  = PH_MISS;
                    end
                end
            end
            PH_MISS: begin
                bus_req = 1'b1;
                if (bus_gnt) begin                // R3, R4, R11
                    bus_valid = 1'b1;
                    bus_cmd   = cpu_req_write ? CMD_WRMISS : CMD_RDMISS;
                    bus_blk   = {req_tag, req_idx};
                    fill_en   = 1'b1;
                    cpu_done  = 1'b1;
                    fsm_d.ph  = PH_IDLE;
                end
            end
            default: begin
                fsm_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{ph: PH_IDLE, vtag: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
    import snoop_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req_valid,
    input  logic                     cpu_req_write,
    input  logic [TAG_W+INDEX_W-1:0] cpu_req_blk,
    output logic                     cpu_done,
    output logic                     cpu_hit,
    output logic                     bus_req,
    input  logic                     bus_gnt,
    output logic                     bus_valid,
    output logic [1:0]               bus_cmd,
    output logic [TAG_W+INDEX_W-1:0] bus_blk,
    input  logic                     snp_valid,
    input  logic [1:0]               snp_cmd,
    input  logic [TAG_W+INDEX_W-1:0] snp_blk,
    output logic                     snp_flush
);
    localparam int BLK_W = TAG_W + INDEX_W;

    logic [INDEX_W-1:0] req_idx, snp_idx;
    logic [TAG_W-1:0]   req_tag, snp_tag_in;
    line_st_t           cpu_line_st, snp_line_st;
    logic [TAG_W-1:0]   cpu_line_tag, snp_line_tag;
    logic               upd_en, fill_en;
    line_st_t           upd_st, fill_st;
    bus_cmd_t           own_cmd;

    assign req_idx    = cpu_req_blk[INDEX_W-1:0];
    assign req_tag    = cpu_req_blk[BLK_W-1:INDEX_W];
    assign snp_idx    = snp_blk[INDEX_W-1:0];
    assign snp_tag_in = snp_blk[BLK_W-1:INDEX_W];
    assign bus_cmd    = own_cmd;

    line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_idx  (req_idx),
        .cpu_st   (cpu_line_st),
        .cpu_tag  (cpu_line_tag),
        .snp_idx  (snp_idx),
        .snp_st   (snp_line_st),
        .snp_tag  (snp_line_tag),
        .upd_en   (upd_en),
        .upd_st   (upd_st),
        .fill_en  (fill_en),
        .fill_tag (req_tag),
        .fill_st  (fill_st)
    );

    snoop_unit #(.TAG_W(TAG_W)) snoop_i (
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_t'(snp_cmd)),
        .snp_tag   (snp_tag_in),
        .line_st   (snp_line_st),
        .line_tag  (snp_line_tag),
        .upd_en    (upd_en),
        .upd_st    (upd_st),
        .flush     (snp_flush)
    );

    proc_fsm #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .req_idx       (req_idx),
        .req_tag       (req_tag),
        .line_st       (cpu_line_st),
        .line_tag      (cpu_line_tag),
        .snp_valid     (snp_valid),
        .bus_gnt       (bus_gnt),
        .bus_req       (bus_req),
        .bus_valid     (bus_valid),
        .bus_cmd       (own_cmd),
        .bus_blk       (bus_blk),
        .cpu_done      (cpu_done),
        .cpu_hit       (cpu_hit),
        .fill_en       (fill_en),
        .fill_st       (fill_st)
    );

endmodule

// File: rtl/snoop_cache_ctrl_chk.sv
module snoop_cache_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_done,
    input logic       cpu_hit,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic       bus_valid,
    input logic [1:0] bus_cmd,
    input logic       snp_valid,
    input logic [1:0] snp_cmd,
    input logic       snp_flush
);
    p_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_req && bus_gnt));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_hit) |-> !bus_valid);

    p_miss_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_cmd == 2'd1 || bus_cmd == 2'd2)) |-> (cpu_done && !cpu_hit));

    p_wb_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == 2'd3) |=> bus_req);

    p_flush_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

    p_snoop_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !(cpu_done && cpu_hit));

endmodule

bind snoop_cache_ctrl snoop_cache_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_done  (cpu_done),
    .cpu_hit   (cpu_hit),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_valid (bus_valid),
    .bus_cmd   (bus_cmd),
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_flush (snp_flush)
);

// File: tb/snoop_cache_ctrl_tb_top.sv
module snoop_cache_ctrl_tb_top;
    localparam int IW = 3;
    localparam int TW = 6;
    localparam int BW = IW + TW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]    c_req = '0;
    logic [1:0]    c_wr  = '0;
    logic [BW-1:0] c_addr [2];
    logic [1:0]    done, hit, breq, gnt, bval, flush;
    logic [1:0]    bcmd [2];
    logic [BW-1:0] bblk [2];

    // fixed-priority arbiter: cache 0 first
    assign gnt[0] = breq[0];
    assign gnt[1] = breq[1] & ~breq[0];

    snoop_cache_ctrl #(.INDEX_W(IW), .TAG_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(c_req[0]), .cpu_req_write(c_wr[0]), .cpu_req_blk(c_addr[0]),
        .cpu_done(done[0]), .cpu_hit(hit[0]),
        .bus_req(breq[0]), .bus_gnt(gnt[0]), .bus_valid(bval[0]),
        .bus_cmd(bcmd[0]), .bus_blk(bblk[0]),
        .snp_valid(bval[1]), .snp_cmd(bcmd[1]), .snp_blk(bblk[1]),
        .snp_flush(flush[0])
    );

    snoop_cache_ctrl #(.INDEX_W(IW), .TAG_W(TW)) peer_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(c_req[1]), .cpu_req_write(c_wr[1]), .cpu_req_blk(c_addr[1]),
        .cpu_done(done[1]), .cpu_hit(hit[1]),
        .bus_req(breq[1]), .bus_gnt(gnt[1]), .bus_valid(bval[1]),
        .bus_cmd(bcmd[1]), .bus_blk(bblk[1]),
        .snp_valid(bval[0]), .snp_cmd(bcmd[0]), .snp_blk(bblk[0]),
        .snp_flush(flush[1])
    );

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model: 0 Invalid, 1 Shared, 2 Exclusive
    int m_st [2][8];
    int m_tg [2][8];

    function automatic logic [BW-1:0] mk(int t, int i);
        return {t[TW-1:0], i[IW-1:0]};
    endfunction

    function automatic bit model_hit(int c, bit w, logic [BW-1:0] a);
        int i = int'(a[IW-1:0]);
        int t = int'(a[BW-1:IW]);
        if (m_tg[c][i] != t) return 1'b0;
        return w ? (m_st[c][i] == 2) : (m_st[c][i] != 0);
    endfunction

    function automatic void model_apply(int c, bit w, logic [BW-1:0] a);
        int i = int'(a[IW-1:0]);
        int t = int'(a[BW-1:IW]);
        int o = 1 - c;
        if (model_hit(c, w, a)) return;
        if (m_st[o][i] != 0 && m_tg[o][i] == t) begin
            if (w) m_st[o][i] = 0;
            else if (m_st[o][i] == 2) m_st[o][i] = 1;
        end
        m_st[c][i] = w ? 2 : 1;
        m_tg[c][i] = t;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic run_op(input int c, input bit w, input logic [BW-1:0] a,
                          input string hrq);
        int  o = 1 - c;
        int  i = int'(a[IW-1:0]);
        int  t = int'(a[BW-1:IW]);
        bit  e_hit, e_wb, e_flush;
        int  e_wbblk;
        bit  got_done = 0, got_hit = 0, fl = 0, gnt_ok = 1;
        int  n_wb = 0, wb_blk = 0, m_cmd = 0, m_blk = 0;
        string rq;
        e_hit   = model_hit(c, w, a);
        e_wb    = !e_hit && m_st[c][i] == 2 && m_tg[c][i] != t;
        e_wbblk = m_tg[c][i] * 8 + i;
        e_flush = !e_hit && m_st[o][i] == 2 && m_tg[o][i] == t;
        @(negedge clk);
        c_req[c] = 1'b1; c_wr[c] = w; c_addr[c] = a;
        for (int k = 0; k < 20; k++) begin
            #1;
            if (bval[c]) begin
                if (!gnt[c]) gnt_ok = 0;
                if (bcmd[c] == 2'd3) begin n_wb++; wb_blk = int'(bblk[c]); end
                else begin m_cmd = int'(bcmd[c]); m_blk = int'(bblk[c]); end
            end
            if (flush[o]) fl = 1;
            if (done[c]) begin got_done = 1; got_hit = hit[c]; break; end
            @(negedge clk);
        end
        @(posedge clk); #1;
        c_req[c] = 1'b0;
        chk(got_done, "R11", "completion", int'(got_done), 1);
        chk(gnt_ok, "R11", "bus only with grant", int'(gnt_ok), 1);
        rq = (hrq != "") ? hrq : (e_hit ? "R2" : "R3");
        chk(got_hit == e_hit, rq, "hit flag", int'(got_hit), int'(e_hit));
        if (e_hit) chk(m_cmd == 0 && n_wb == 0, "R2", "bus quiet on hit", m_cmd, 0);
        else begin
            chk(m_cmd == (w ? 2 : 1), w ? "R4" : "R3", "miss command", m_cmd, w ? 2 : 1);
            chk(m_blk == int'(a), w ? "R4" : "R3", "miss block", m_blk, int'(a));
        end
        chk(n_wb == int'(e_wb), "R5", "write-back count", n_wb, int'(e_wb));
        if (e_wb) chk(wb_blk == e_wbblk, "R5", "victim block", wb_blk, e_wbblk);
        chk(fl == e_flush, w ? "R8" : "R7", "peer flush", int'(fl), int'(e_flush));
        model_apply(c, w, a);
    endtask

    initial begin
        c_addr[0] = '0; c_addr[1] = '0;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 8; i++) begin m_st[c][i] = 0; m_tg[c][i] = 0; end
        repeat (4) @(negedge clk);
        #1;
        chk(breq == 2'b00 && bval == 2'b00 && done == 2'b00, "R1", "reset outputs",
            int'({breq, bval, done}), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 R3 R2 R4: first read misses, then hit, write to Shared misses
        run_op(0, 0, mk(1, 0), "R1");
        run_op(0, 0, mk(1, 0), "R2");
        run_op(0, 1, mk(1, 0), "R4");
        run_op(0, 1, mk(1, 0), "R2");
        // R7: peer read takes dirty copy, owner downgrades
        run_op(1, 0, mk(1, 0), "");
        run_op(0, 0, mk(1, 0), "R7");
        run_op(0, 1, mk(1, 0), "R4");
        // R6: peer's Shared copy was invalidated by that write miss
        run_op(1, 0, mk(1, 0), "R6");
        // R8: write miss against an Exclusive owner
        run_op(1, 1, mk(1, 0), "R4");
        run_op(0, 1, mk(1, 0), "R8");
        run_op(1, 0, mk(1, 0), "R8");
        // R5: replacements of dirty lines
        run_op(0, 1, mk(1, 0), "R4");
        run_op(0, 0, mk(2, 0), "R5");
        run_op(0, 1, mk(3, 0), "R4");
        run_op(0, 1, mk(1, 0), "R5");
        run_op(0, 1, mk(1, 0), "R5");
        // R9: same index, other tag leaves the peer line untouched
        run_op(1, 1, mk(5, 1), "R4");
        run_op(0, 0, mk(6, 1), "R9");
        run_op(1, 1, mk(5, 1), "R9");
        run_op(1, 1, mk(7, 1), "R5");

        // R10: peer request arrives while a snooped transaction is on the bus
        @(negedge clk);
        c_req[0] = 1'b1; c_wr[0] = 1'b1; c_addr[0] = mk(1, 2);
        @(negedge clk);
        c_req[1] = 1'b1; c_wr[1] = 1'b0; c_addr[1] = mk(7, 1);
        #1;
        chk(bval[0] == 1'b1 && done[1] == 1'b0, "R10", "request deferred by snoop",
            int'(done[1]), 0);
        chk(done[0] == 1'b1 && hit[0] == 1'b0, "R11", "miss done in grant cycle",
            int'({done[0], hit[0]}), 2);
        @(posedge clk); #1; c_req[0] = 1'b0;
        @(negedge clk); #1;
        chk(done[1] == 1'b1 && hit[1] == 1'b1, "R10", "deferred request served",
            int'({done[1], hit[1]}), 3);
        @(posedge clk); #1; c_req[1] = 1'b0;
        model_apply(0, 1, mk(1, 2));

        // constrained random traffic on two indices, four tags
        void'($urandom(32'd20240611));
        for (int n = 0; n < 400; n++) begin
            int  c  = int'($urandom_range(0, 1));
            bit  w  = bit'($urandom_range(0, 1));
            int  tg = int'($urandom_range(0, 3));
            int  ix = int'($urandom_range(0, 1));
            run_op(c, w, mk(tg, ix), "");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule